// File: doc/BRIEF.md
# Shift, Rotate and Extend Unit

This block computes the shift-group operations of a 16-bit ALU. A decoder, its register file and its write-back path surround it. Each cycle the unit takes five inputs:

- the source operand;
- the three opcode bits of the instruction word (bits 14..12);
- the five low instruction bits (bits 4..0);
- a second register value, which sets the amount for a variable rotation;
- the current carry flag.

From these it forms a 16-bit result, a new carry, and the zero and negative flags. All four land in output registers one clock later.

The unit covers six groups of operation:

- one-bit logical, arithmetic and rotate-through-carry shifts, left and right;
- left rotation by a 4-bit immediate amount;
- left rotation by the low four bits of a register operand;
- byte sign extension;
- bitwise invert;
- a pass-through when the instruction is not a shift-group word (bit 4 clear).

The one-bit shifts and the multi-bit rotations share a single sub-decode of the low bits. Opcode bit 12 selects the shift direction.

Top module: `bitmove_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs become result 0x0000, carry 0, zero 1 and negative 0.
- R2: Every output reflects the inputs that were present at the previous rising clock edge. Back-to-back operations each appear one cycle after their own inputs.
- R3: With `op_i` = 010 and `low_i[4]` = 1, the unit shifts left by one bit. A zero enters bit 0 and the old bit 15 becomes the carry. This holds for `low_i[3:2]` = 00 (plain) and also when `low_i[2]` = 1 (arithmetic left).
- R4: With `op_i` = 011 and `low_i[4]` = 1, the unit shifts right by one bit and the old bit 0 becomes the carry. When `low_i[3:2]` = 00 (plain), a zero enters bit 15. When `low_i[2]` = 1 (arithmetic), the old bit 15 is kept in bit 15.
- R5: With `low_i[4:2]` = 110, opcode 010 rotates left through carry and opcode 011 rotates right through carry. The incoming carry fills the vacated bit, and the bit shifted out becomes the new carry.
- R6: With `op_i` = 101 and `low_i[4]` = 1, the source is rotated left by `low_i[3:0]` positions. The top bits wrap into the bottom bits.
- R7: With `op_i` = 100 and `low_i[4]` = 1, the source is rotated left by `amt_reg_i[3:0]`. All higher bits of `amt_reg_i` are ignored.
- R8: A rotation amount of zero returns the source unchanged. Both multi-bit rotations output the incoming carry unchanged.
- R9: With `op_i` = 000 or 001 and `low_i[4]` = 1, the result is `src_i[7:0]` with bit 7 copied into bits 15..8. `low_i[3:0]` has no effect, and the carry passes through unchanged.
- R10: With `op_i` = 110 or 111 and `low_i[4]` = 1, the result is the bitwise inverse of the source. `low_i[3:0]` has no effect, and the carry passes through unchanged.
- R11: The zero flag is 1 exactly when the registered result is 0x0000. The negative flag equals bit 15 of the registered result.
- R12: When `low_i[4]` = 0, the result equals the source and the carry passes through unchanged, whatever the opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Instruction bits 14..12 |
| low_i | input | 5 | Instruction bits 4..0 |
| src_i | input | 16 | Source operand |
| amt_reg_i | input | 16 | Register operand that holds the variable rotation amount |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 16 | Registered result |
| carry_o | output | 1 | Registered new carry |
| zero_o | output | 1 | Registered zero flag |
| neg_o | output | 1 | Registered negative flag |

## Verification
The data path from the inputs to the outputs passes through exactly one register stage. Every result and every flag is therefore due at the first rising edge after its inputs are applied. The bench changes the inputs on a falling edge and reads all four outputs on the next falling edge, half a period after the capturing edge, so each check sees exactly one operation. The reset values are read on the falling edge after a reset edge. The back-to-back sequences confirm that each result belongs only to its own inputs.

// File: rtl/bm_pkg.sv
package bm_pkg;
  localparam int DATA_W   = 16;
  localparam int OP_W     = 3;
  localparam int LOW_W    = 5;

  typedef enum logic [1:0] {
    KIND_PLAIN,
    KIND_RTC,
    KIND_ARITH
  } shift_kind_t;

  typedef enum logic [2:0] {
    SEL_PASS,
    SEL_SHIFT,
    SEL_ROT_IMM,
    SEL_ROT_REG,
    SEL_SEXT,
    SEL_INV
  } unit_sel_t;
endpackage

// File: rtl/bm_decode.sv
module bm_decode
  import bm_pkg::*;
#(
  parameter int OPW  = OP_W,
  parameter int LOWW = LOW_W
) (
  input  logic [OPW-1:0]  op,
  input  logic [LOWW-1:0] low,
  output unit_sel_t       sel,
  output logic            dir_right,
  output shift_kind_t     kind
);
  always_comb begin
    dir_right = op[0];
    if (low[2])       kind = KIND_ARITH;
    else if (low[3])  kind = KIND_RTC;
    else              kind = KIND_PLAIN;

    if (!low[4]) begin
      sel = SEL_PASS;
    end else begin
      unique case (op)
        3'b000, 3'b001: sel = SEL_SEXT;
        3'b010, 3'b011: sel = SEL_SHIFT;
        3'b100:         sel = SEL_ROT_REG;
        3'b101:         sel = SEL_ROT_IMM;
        default:        sel = SEL_INV;
      endcase
    end
  end
endmodule

// File: rtl/bm_shift1.sv
module bm_shift1
  import bm_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] din,
  input  logic         dir_right,
  input  shift_kind_t  kind,
  input  logic         cin,
  output logic [W-1:0] dout,
  output logic         cout
);
  logic fill;

  always_comb begin
    if (dir_right) begin
      unique case (kind)
        KIND_RTC:   fill = cin;
        KIND_ARITH: fill = din[W-1];
        default:    fill = 1'b0;
      endcase
      dout = {fill, din[W-1:1]};
      cout = din[0];
    end else begin
      fill = (kind == KIND_RTC) ? cin : 1'b0;
      dout = {din[W-2:0], fill};
      cout = din[W-1];
    end
  end

  // R5: a rotate through carry conserves the ones over data plus carry
  always_comb begin
    if (kind == KIND_RTC)
      assert_rtc_conserves_R5: assert ($countones({dout, cout}) == $countones({din, cin}));
  end
endmodule

// File: rtl/bm_barrel.sv
module bm_barrel
  import bm_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stage [0:AW];

  assign stage[0] = din;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign stage[k+1] = amt[k] ? {stage[k][W-SH-1:0], stage[k][W-1:W-SH]}
                               : stage[k];
  end

  assign dout = stage[AW];

  // R8 and R6: a zero amount is the identity, and any rotation keeps the ones count
  always_comb begin
    if (amt == '0)
      assert_zero_amt_identity_R8: assert (dout == din);
    assert_rot_keeps_ones_R6: assert ($countones(dout) == $countones(din));
  end
endmodule

// File: rtl/bitmove_unit.sv
module bitmove_unit
  import bm_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    op_i,
  input  logic [4:0]    low_i,
  input  logic [DW-1:0] src_i,
  input  logic [DW-1:0] amt_reg_i,
  input  logic          carry_i,
  output logic [DW-1:0] result_o,
  output logic          carry_o,
  output logic          zero_o,
  output logic          neg_o
);
  localparam int AMT_W  = $clog2(DW);
  localparam int BYTE_W = 8;

  unit_sel_t    sel_c;
  logic         dir_right_c;
  shift_kind_t  kind_c;
  logic [DW-1:0] sh_res_c, rot_res_c, res_c;
  logic          sh_c, carry_c;
  logic [AMT_W-1:0] amt_c;

  bm_decode u_dec (
    .op        (op_i),
    .low       (low_i),
    .sel       (sel_c),
    .dir_right (dir_right_c),
    .kind      (kind_c)
  );

  bm_shift1 #(.W(DW)) u_sh1 (
    .din       (src_i),
    .dir_right (dir_right_c),
    .kind      (kind_c),
    .cin       (carry_i),
    .dout      (sh_res_c),
    .cout      (sh_c)
  );

  assign amt_c = (sel_c == SEL_ROT_IMM) ? low_i[AMT_W-1:0] : amt_reg_i[AMT_W-1:0];

  bm_barrel #(.W(DW), .AW(AMT_W)) u_rot (
    .din  (src_i),
    .amt  (amt_c),
    .dout (rot_res_c)
  );

  always_comb begin
    carry_c = carry_i;
    unique case (sel_c)
      SEL_SHIFT: begin
        res_c   = sh_res_c;
        carry_c = sh_c;
      end
      SEL_ROT_IMM, SEL_ROT_REG: res_c = rot_res_c;
      SEL_SEXT: res_c = {{(DW-BYTE_W){src_i[BYTE_W-1]}}, src_i[BYTE_W-1:0]};
      SEL_INV:  res_c = ~src_i;
      default:  res_c = src_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      carry_o  <= 1'b0;
      zero_o   <= 1'b1;
      neg_o    <= 1'b0;
    end else begin
      result_o <= res_c;
      carry_o  <= carry_c;
      zero_o   <= ~|res_c;
      neg_o    <= res_c[DW-1];
    end
  end

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R11: flags agree with the registered result
  assert_zero_flag_R11: assert property (@(posedge clk) disable iff (rst)
    zero_o == (result_o == '0));
  assert_neg_flag_R11: assert property (@(posedge clk) disable iff (rst)
    neg_o == result_o[DW-1]);

  // R8: multi-bit rotations keep the carry
  assert_rot_keeps_carry_R8: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(sel_c == SEL_ROT_IMM || sel_c == SEL_ROT_REG)
      |-> carry_o == $past(carry_i));

  // R10: invert one cycle later
  assert_invert_R10: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(sel_c == SEL_INV) |-> result_o == ~$past(src_i));

  // R12: non-group words pass through
  assert_pass_through_R12: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(low_i[4] == 1'b0)
      |-> (result_o == $past(src_i)) && (carry_o == $past(carry_i)));
endmodule

// File: tb/bitmove_unit_tb.sv
module bitmove_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_i = '0;
  logic [4:0]  low_i = '0;
  logic [15:0] src_i = '0;
  logic [15:0] amt_reg_i = '0;
  logic        carry_i = 1'b0;
  logic [15:0] result_o;
  logic        carry_o, zero_o, neg_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bitmove_unit u_dut (
    .clk(clk), .rst(rst), .op_i(op_i), .low_i(low_i), .src_i(src_i),
    .amt_reg_i(amt_reg_i), .carry_i(carry_i), .result_o(result_o),
    .carry_o(carry_o), .zero_o(zero_o), .neg_o(neg_o)
  );

  function automatic logic [15:0] rotl(input logic [15:0] v, input int n);
    logic [31:0] d;
    d = {v, v} << n;
    return d[31:16];
  endfunction

  task automatic check(input string tag, input logic [15:0] er, input logic ec);
    logic ez, en;
    ez = (er == 16'h0);
    en = er[15];
    checks++;
    if (result_o !== er || carry_o !== ec || zero_o !== ez || neg_o !== en) begin
      errors++;
      $display("FAIL %s: got res=%h c=%b z=%b n=%b, expected res=%h c=%b z=%b n=%b",
               tag, result_o, carry_o, zero_o, neg_o, er, ec, ez, en);
    end
  endtask

  // drive on a falling edge, result due at the next rising edge, read on the falling edge after it
  task automatic run(input logic [2:0] op, input logic [4:0] low, input logic [15:0] src,
                     input logic [15:0] rb, input logic cin, input string tag,
                     input logic [15:0] er, input logic ec);
    op_i = op; low_i = low; src_i = src; amt_reg_i = rb; carry_i = cin;
    @(negedge clk);
    check(tag, er, ec);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    src_i = 16'hFFFF; carry_i = 1'b1; low_i = 5'b10000; op_i = 3'b110;
    @(negedge clk);
    check("R1 reset", 16'h0000, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_left;
    run(3'b010, 5'b10000, 16'h8001, 16'h0, 1'b0, "R3 shl", 16'h0002, 1'b1);
    run(3'b010, 5'b10100, 16'h4003, 16'h0, 1'b1, "R3 ashl", 16'h8006, 1'b0);
  endtask

  task automatic t_right;
    run(3'b011, 5'b10000, 16'h8001, 16'h0, 1'b1, "R4 shr", 16'h4000, 1'b1);
    run(3'b011, 5'b10100, 16'h8002, 16'h0, 1'b1, "R4 ashr", 16'hC001, 1'b0);
    run(3'b011, 5'b11111, 16'h7FFE, 16'h0, 1'b0, "R4 ashr bit3 set", 16'h3FFF, 1'b0);
  endtask

  task automatic t_rtc;
    run(3'b010, 5'b11000, 16'h8000, 16'h0, 1'b1, "R5 rolc cin1", 16'h0001, 1'b1);
    run(3'b010, 5'b11000, 16'h8000, 16'h0, 1'b0, "R5 rolc cin0", 16'h0000, 1'b1);
    run(3'b011, 5'b11000, 16'h0001, 16'h0, 1'b1, "R5 rorc", 16'h8000, 1'b1);
  endtask

  task automatic t_rot_imm;
    run(3'b101, 5'b10100, 16'h1234, 16'h0, 1'b1, "R6 roti 4", 16'h2341, 1'b1);
    run(3'b101, 5'b11111, 16'h8001, 16'h0, 1'b0, "R6 roti 15", 16'hC000, 1'b0);
    for (int n = 1; n < 16; n += 5)
      run(3'b101, 5'(5'h10 | n), 16'hA5C3, 16'h0, 1'b1, "R6 roti sweep", rotl(16'hA5C3, n), 1'b1);
  endtask

  task automatic t_rot_reg;
    run(3'b100, 5'b10000, 16'h1234, 16'h00F3, 1'b0, "R7 rot reg 3", 16'h91A0, 1'b0);
    run(3'b100, 5'b10101, 16'h8421, 16'hFFF9, 1'b1, "R7 rot reg upper ignored", rotl(16'h8421, 9), 1'b1);
  endtask

  task automatic t_zero_amt;
    run(3'b101, 5'b10000, 16'hBEEF, 16'h0, 1'b1, "R8 roti 0", 16'hBEEF, 1'b1);
    run(3'b100, 5'b10000, 16'h0F00, 16'h0010, 1'b0, "R8 rot reg 0", 16'h0F00, 1'b0);
  endtask

  task automatic t_sext;
    run(3'b000, 5'b11111, 16'h12F0, 16'h0, 1'b1, "R9 sext neg", 16'hFFF0, 1'b1);
    run(3'b001, 5'b10000, 16'hAB7F, 16'h0, 1'b0, "R9 sext pos", 16'h007F, 1'b0);
  endtask

  task automatic t_inv;
    run(3'b110, 5'b10000, 16'h0F0F, 16'h0, 1'b1, "R10 inv", 16'hF0F0, 1'b1);
    run(3'b111, 5'b11010, 16'hFFFF, 16'h0, 1'b0, "R10 inv to zero R11", 16'h0000, 1'b0);
  endtask

  task automatic t_pass;
    run(3'b010, 5'b01100, 16'h5A5A, 16'h0, 1'b1, "R12 pass shift op", 16'h5A5A, 1'b1);
    run(3'b110, 5'b00000, 16'h8000, 16'h0, 1'b0, "R12 pass inv op R11", 16'h8000, 1'b0);
  endtask

  task automatic t_back_to_back;
    run(3'b110, 5'b10000, 16'h0001, 16'h0, 1'b0, "R2 b2b first", 16'hFFFE, 1'b0);
    run(3'b010, 5'b10000, 16'h0001, 16'h0, 1'b0, "R2 b2b second", 16'h0002, 1'b0);
    run(3'b011, 5'b10000, 16'h0001, 16'h0, 1'b0, "R2 b2b third", 16'h0000, 1'b1);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    t_left();
    t_right();
    t_rtc();
    t_rot_imm();
    t_rot_reg();
    t_zero_amt();
    t_sext();
    t_inv();
    t_pass();
    t_back_to_back();
    t_reset();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule